// File: doc/BRIEF.md
# Three-Buffer Output/Input Data Exchange Pointer Manager

This block manages the ownership of three data buffers for cyclic process data without copying any data. In the output direction the bus receiver fills the "fill" buffer (role D). When a frame arrives without error, that buffer is published as the "newest" buffer (role N). The user claims the newest data by issuing a fetch command, which gives N to the user (role U). A clear request can arrive at power-on, when the master leaves, or from a clear-data control. The block then asks an external clearer to zero the fill buffer. When the clearer acknowledges, the block publishes the zeroed buffer as newest and marks it as cleared, so the user's next fetch reports that it received a cleared buffer.

The input direction uses the mirror policy. The user publishes a freshly written buffer with a push command, and U and N swap. Before each transmission the sender fetches N into D, but only if a new N exists and the freeze input is low. The block holds only buffer indices, status and handshakes. The buffer storage and the clearing engine are outside the block.

Top module: `triple_buffer_exchange`

## Requirements
- R1: After a synchronous active-high reset, both directions hold indices D=1, N=2, U=3. The fetch status is 0, the cleared flag is 0, and dx_irq and clr_busy are low.
- R2: A receive-ok pulse, when accepted, swaps D and N and leaves U unchanged in the following cycle. It also makes dx_irq high for exactly that one cycle.
- R3: A receive-error pulse changes no index, raises no interrupt and leaves the fetch status as it was.
- R4: A fetch when a new N exists swaps U and N. fetch_stat then shows the new U index, coded 1, 2 or 3, and holds it until the next fetch.
- R5: A fetch when no new N exists leaves U unchanged and reports fetch_stat = 0 (Nil) with fetch_cleared = 0.
- R6: A clear request raises clr_busy from the next cycle, and clr_idx names the current D. When clr_ack is seen while clr_busy is high, D and N swap, clr_busy drops and the cleared buffer becomes a new N. No interrupt is raised for it.
- R7: fetch_cleared is 1 after a fetch that took a buffer published by a clear, and 0 after a fetch that took a buffer published by a receive-ok.
- R8: A receive-ok pulse in the same cycle as a clear request, or while clr_busy is high, is ignored.
- R9: A receive-ok and a fetch with a new N in the same cycle rotate all three roles: U takes the old N, N takes the old D, D takes the old U. dx_irq is raised.
- R10: In each direction the three indices are always distinct and nonzero.
- R11: A push swaps U and N in the input direction, marks N as new, and reports the new U index on push_stat.
- R12: A transmit fetch with a new N and freeze low swaps D and N and consumes the new mark. A transmit fetch without a new N changes nothing.
- R13: While freeze is high a transmit fetch swaps nothing and the new mark is kept, so the first transmit fetch after freeze drops performs the swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_done_ok | input | 1 | Output frame received without error (pulse) |
| rx_done_err | input | 1 | Output frame received with error (pulse) |
| usr_fetch | input | 1 | User command to take the newest output buffer |
| clr_req | input | 1 | Clear request (power-on, master leave, clear-data) |
| clr_ack | input | 1 | External clearer finished zeroing clr_idx |
| usr_push | input | 1 | User command to publish its input buffer |
| tx_fetch | input | 1 | Sender takes newest input buffer before sending |
| freeze | input | 1 | Blocks the input-direction fetch swap |
| out_d_idx | output | 2 | Output fill buffer index |
| out_n_idx | output | 2 | Output newest buffer index |
| out_u_idx | output | 2 | Output user buffer index |
| dx_irq | output | 1 | One-cycle new-output-data interrupt |
| fetch_stat | output | 2 | Result of last fetch: 0 Nil, else buffer 1..3 |
| fetch_cleared | output | 1 | Last fetched buffer was a cleared one |
| clr_busy | output | 1 | Clear in progress, waiting for clr_ack |
| clr_idx | output | 2 | Buffer the clearer must zero |
| in_d_idx | output | 2 | Input sending buffer index |
| in_n_idx | output | 2 | Input newest buffer index |
| in_u_idx | output | 2 | Input user buffer index |
| push_stat | output | 2 | Buffer index handed to the user by the last push |

## Verification
The bench works through the collisions that a pointer rotator most easily gets wrong. A receive and a fetch in the same cycle must produce a three-way rotation; an ordering bug would duplicate an index or hand the user stale data. A receive that coincides with a clear, or arrives during one, must be dropped; a design that accepted it would overwrite the cleared buffer and raise a spurious interrupt. The cleared mark must follow the buffer through the fetch. A repeated fetch with no new data must report Nil and keep U; a design without this would give the user back its own old buffer. On the input side a frozen send must neither swap nor lose the pending mark; a design that lost it would never deliver the pushed data.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  localparam int IDX_W = 2;
  typedef logic [IDX_W-1:0] bidx_t;
  localparam bidx_t IDX_NIL = '0;
  localparam bidx_t IDX_A   = bidx_t'(1);
  localparam bidx_t IDX_B   = bidx_t'(2);
  localparam bidx_t IDX_C   = bidx_t'(3);

  function automatic logic trio_ok(bidx_t a, bidx_t b, bidx_t c);
    return (a != IDX_NIL) && (b != IDX_NIL) && (c != IDX_NIL) &&
           (a != b) && (b != c) && (a != c);
  endfunction
endpackage

// File: rtl/clr_seq.sv
module clr_seq (
  input  logic clk,
  input  logic rst,
  input  logic clr_req,
  input  logic clr_ack,
  input  logic rx_ok,
  output logic busy,
  output logic done,
  output logic rx_pass
);
  logic busy_q;

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else if (busy_q) busy_q <= ~clr_ack;
    else busy_q <= clr_req;
  end

  always_comb begin
    done    = busy_q & clr_ack;
    rx_pass = rx_ok & ~clr_req & ~busy_q;
  end

  assign busy = busy_q;
endmodule

// File: rtl/out_xchg.sv
module out_xchg
  import xchg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  rx_pub,
  input  logic  rx_err,
  input  logic  clr_done,
  input  logic  usr_next,
  output bidx_t d_idx,
  output bidx_t n_idx,
  output bidx_t u_idx,
  output logic  irq,
  output bidx_t stat,
  output logic  cleared
);
  bidx_t d_q, n_q, u_q, stat_q;
  logic  new_q, ncl_q, irq_q, clf_q;
  bidx_t d1, n1, u1, d2, n2, stat1;
  logic  new1, new2, ncl2, clf1;

  always_comb begin
    // user stage sees the state before this cycle's publish
    u1 = u_q; n1 = n_q; d1 = d_q; new1 = new_q;
    stat1 = stat_q; clf1 = clf_q;
    if (usr_next) begin
      if (new_q) begin
        u1 = n_q; n1 = u_q; new1 = 1'b0;
        stat1 = n_q; clf1 = ncl_q;
      end else begin
        stat1 = IDX_NIL; clf1 = 1'b0;
      end
    end
    // publish stage
    d2 = d1; n2 = n1; new2 = new1; ncl2 = ncl_q;
    if (clr_done || rx_pub) begin
      d2 = n1; n2 = d1; new2 = 1'b1; ncl2 = clr_done;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_q <= IDX_A; n_q <= IDX_B; u_q <= IDX_C;
      new_q <= 1'b0; ncl_q <= 1'b0; irq_q <= 1'b0;
      stat_q <= IDX_NIL; clf_q <= 1'b0;
    end else begin
      d_q <= d2; n_q <= n2; u_q <= u1;
      new_q <= new2; ncl_q <= ncl2;
      irq_q <= rx_pub & ~clr_done;
      stat_q <= stat1; clf_q <= clf1;
    end
  end

  assign d_idx = d_q;
  assign n_idx = n_q;
  assign u_idx = u_q;
  assign irq = irq_q;
  assign stat = stat_q;
  assign cleared = clf_q;

  // R10
  out_distinct_chk: assert property (@(posedge clk) disable iff (rst)
    trio_ok(d_q, n_q, u_q));
  // R3
  out_err_still_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_err && !rx_pub && !clr_done && !usr_next) |=>
      ($stable(d_q) && $stable(n_q) && $stable(u_q) && !irq_q));
  // R5
  out_nil_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (usr_next && !new_q) |=> (u_q == $past(u_q) && stat_q == IDX_NIL));
endmodule

// File: rtl/in_xchg.sv
module in_xchg
  import xchg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  usr_push,
  input  logic  snd_fetch,
  input  logic  freeze,
  output bidx_t d_idx,
  output bidx_t n_idx,
  output bidx_t u_idx,
  output bidx_t stat
);
  bidx_t d_q, n_q, u_q, stat_q;
  bidx_t d1, n1, u1, n2, d2, stat1;
  logic  new_q, new1, new2;

  always_comb begin
    d1 = d_q; n1 = n_q; u1 = u_q; new1 = new_q; stat1 = stat_q;
    if (usr_push) begin
      u1 = n_q; n1 = u_q; new1 = 1'b1; stat1 = n_q;
    end
    d2 = d1; n2 = n1; new2 = new1;
    if (snd_fetch && new1 && !freeze) begin
      d2 = n1; n2 = d1; new2 = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_q <= IDX_A; n_q <= IDX_B; u_q <= IDX_C;
      new_q <= 1'b0; stat_q <= IDX_NIL;
    end else begin
      d_q <= d2; n_q <= n2; u_q <= u1;
      new_q <= new2; stat_q <= stat1;
    end
  end

  assign d_idx = d_q;
  assign n_idx = n_q;
  assign u_idx = u_q;
  assign stat = stat_q;

  // R10
  in_distinct_chk: assert property (@(posedge clk) disable iff (rst)
    trio_ok(d_q, n_q, u_q));
  // R13
  in_freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (freeze && !usr_push) |=> ($stable(d_q) && $stable(n_q)));
endmodule

// File: rtl/triple_buffer_exchange.sv
module triple_buffer_exchange
  import xchg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_done_ok,
  input  logic             rx_done_err,
  input  logic             usr_fetch,
  input  logic             clr_req,
  input  logic             clr_ack,
  input  logic             usr_push,
  input  logic             tx_fetch,
  input  logic             freeze,
  output logic [IDX_W-1:0] out_d_idx,
  output logic [IDX_W-1:0] out_n_idx,
  output logic [IDX_W-1:0] out_u_idx,
  output logic             dx_irq,
  output logic [IDX_W-1:0] fetch_stat,
  output logic             fetch_cleared,
  output logic             clr_busy,
  output logic [IDX_W-1:0] clr_idx,
  output logic [IDX_W-1:0] in_d_idx,
  output logic [IDX_W-1:0] in_n_idx,
  output logic [IDX_W-1:0] in_u_idx,
  output logic [IDX_W-1:0] push_stat
);
  logic busy, done, rx_pass;

  clr_seq i_clr (
    .clk(clk), .rst(rst), .clr_req(clr_req), .clr_ack(clr_ack),
    .rx_ok(rx_done_ok), .busy(busy), .done(done), .rx_pass(rx_pass)
  );

  out_xchg i_out (
    .clk(clk), .rst(rst), .rx_pub(rx_pass), .rx_err(rx_done_err),
    .clr_done(done), .usr_next(usr_fetch),
    .d_idx(out_d_idx), .n_idx(out_n_idx), .u_idx(out_u_idx),
    .irq(dx_irq), .stat(fetch_stat), .cleared(fetch_cleared)
  );

  in_xchg i_in (
    .clk(clk), .rst(rst), .usr_push(usr_push), .snd_fetch(tx_fetch),
    .freeze(freeze), .d_idx(in_d_idx), .n_idx(in_n_idx),
    .u_idx(in_u_idx), .stat(push_stat)
  );

  assign clr_busy = busy;
  assign clr_idx  = out_d_idx;

  // R8
  busy_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !dx_irq);
  // R6
  clr_target_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !clr_ack) |=> $stable(out_d_idx));
endmodule

// File: tb/test_triple_buffer_exchange.sv
module test_triple_buffer_exchange;
  logic clk = 0;
  logic rst = 1;
  logic rx_ok = 0, rx_err = 0, ufetch = 0, creq = 0, cack = 0;
  logic upush = 0, txf = 0, frz = 0;
  logic [1:0] od, on, ou, fstat, cidx, idd, inn, iu, pstat;
  logic irq, fclr, busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  triple_buffer_exchange i_triple_buffer_exchange (
    .clk(clk), .rst(rst), .rx_done_ok(rx_ok), .rx_done_err(rx_err),
    .usr_fetch(ufetch), .clr_req(creq), .clr_ack(cack), .usr_push(upush),
    .tx_fetch(txf), .freeze(frz), .out_d_idx(od), .out_n_idx(on),
    .out_u_idx(ou), .dx_irq(irq), .fetch_stat(fstat),
    .fetch_cleared(fclr), .clr_busy(busy), .clr_idx(cidx),
    .in_d_idx(idd), .in_n_idx(inn), .in_u_idx(iu), .push_stat(pstat)
  );

  typedef struct {
    string tag;
    logic [1:0] d, n, u, st, id, in_, iu, ps;
    logic irq, clf, busy;
  } exp_t;

  exp_t q[$];

  // reference state
  logic [1:0] m_d = 1, m_n = 2, m_u = 3, m_st = 0;
  logic [1:0] i_d = 1, i_n = 2, i_u = 3, i_st = 0;
  logic m_new = 0, m_ncl = 0, m_clf = 0, m_busy = 0, m_irq = 0, i_new = 0;

  task automatic chk(string tag, string f, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, f, act, exp);
    end
  endtask

  task automatic step(string tag, logic a_ok, logic a_err, logic a_f,
                      logic a_cr, logic a_ca, logic a_p, logic a_t,
                      logic a_z);
    logic [1:0] t;
    logic cdone, gate;
    exp_t e;
    @(negedge clk);
    rx_ok = a_ok; rx_err = a_err; ufetch = a_f; creq = a_cr;
    cack = a_ca; upush = a_p; txf = a_t; frz = a_z;
    cdone = m_busy && a_ca;
    gate = a_ok && !a_cr && !m_busy;
    m_busy = m_busy ? !a_ca : a_cr;
    m_irq = 0;
    if (a_f) begin
      if (m_new) begin
        t = m_u; m_u = m_n; m_n = t; m_new = 0;
        m_st = m_u; m_clf = m_ncl;
      end else begin
        m_st = 0; m_clf = 0;
      end
    end
    if (cdone || gate) begin
      t = m_d; m_d = m_n; m_n = t; m_new = 1; m_ncl = cdone;
      m_irq = gate;
    end
    if (a_p) begin
      t = i_u; i_u = i_n; i_n = t; i_new = 1; i_st = i_u;
    end
    if (a_t && i_new && !a_z) begin
      t = i_d; i_d = i_n; i_n = t; i_new = 0;
    end
    e.tag = tag; e.d = m_d; e.n = m_n; e.u = m_u; e.st = m_st;
    e.irq = m_irq; e.clf = m_clf; e.busy = m_busy;
    e.id = i_d; e.in_ = i_n; e.iu = i_u; e.ps = i_st;
    @(posedge clk);
    #1 q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "out_d", od, e.d);
      chk(e.tag, "out_n", on, e.n);
      chk(e.tag, "out_u", ou, e.u);
      chk(e.tag, "dx_irq", irq, e.irq);
      chk(e.tag, "fetch_stat", fstat, e.st);
      chk(e.tag, "fetch_cleared", fclr, e.clf);
      chk(e.tag, "clr_busy", busy, e.busy);
      if (e.busy) chk(e.tag, "clr_idx", cidx, e.d);
      chk(e.tag, "in_d", idd, e.id);
      chk(e.tag, "in_n", inn, e.in_);
      chk(e.tag, "in_u", iu, e.iu);
      chk(e.tag, "push_stat", pstat, e.ps);
      // R10 distinct indices observed at the ports
      chk("R10", "out_distinct",
          int'(od != on && on != ou && od != ou && od != 0 && on != 0 && ou != 0), 1);
      chk("R10", "in_distinct",
          int'(idd != inn && inn != iu && idd != iu && idd != 0 && inn != 0 && iu != 0), 1);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    //            tag   ok err fch crq cak psh txf frz
    step("R1",  0,0,0,0,0,0,0,0);
    step("R2",  1,0,0,0,0,0,0,0);
    step("R2",  0,0,0,0,0,0,0,0);
    step("R3",  0,1,0,0,0,0,0,0);
    step("R4",  0,0,1,0,0,0,0,0);
    step("R7",  0,0,0,0,0,0,0,0);
    step("R5",  0,0,1,0,0,0,0,0);
    step("R6",  0,0,0,1,0,0,0,0);
    step("R6",  0,0,0,0,0,0,0,0);
    step("R8",  1,0,0,0,0,0,0,0);
    step("R6",  0,0,0,0,1,0,0,0);
    step("R7",  0,0,1,0,0,0,0,0);
    step("R8",  1,0,0,1,0,0,0,0);
    step("R8",  0,0,0,0,1,0,0,0);
    step("R2",  1,0,0,0,0,0,0,0);
    step("R9",  1,0,1,0,0,0,0,0);
    step("R4",  0,0,1,0,0,0,0,0);
    step("R5",  0,0,1,0,0,0,0,0);
    step("R3",  0,1,1,0,0,0,0,0);
    step("R11", 0,0,0,0,0,1,0,0);
    step("R12", 0,0,0,0,0,0,1,0);
    step("R12", 0,0,0,0,0,0,1,0);
    step("R11", 0,0,0,0,0,1,0,0);
    step("R13", 0,0,0,0,0,0,1,1);
    step("R13", 0,0,0,0,0,0,0,1);
    step("R13", 0,0,0,0,0,0,1,0);
    step("R11", 0,0,0,0,0,1,1,0);
    step("R12", 0,0,0,0,0,0,1,0);
    step("R1",  0,0,0,0,0,0,0,0);
    @(negedge clk);
    rx_ok = 0; rx_err = 0; ufetch = 0; creq = 0; cack = 0;
    upush = 0; txf = 0; frz = 0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule